// File: doc/BRIEF.md
# Four-Function Calculator Datapath

This block is a purely combinational arithmetic core for a tiny calculator. It takes two operand buses and a 2-bit operation code. It adds, subtracts, multiplies or divides, and drives two seven-segment digits with the decimal value of the outcome. Each operation reads only as many low operand bits as it supports. Add and subtract use 4 bits, multiply uses 3 bits and divide uses 2 bits.

Subtraction never shows a two's-complement pattern. When the second operand exceeds the first, the raw borrow-chain output is complemented a second time to give a plain magnitude, and a separate sign flag is raised. The binary outcome is also available as a 6-bit bus. The two-digit decimal converter covers the whole multiply range up to 49.

Top module: `calc_core`

## Requirements
- R1: With op_i = 2'b00, result_o equals a_i + b_i over the full 4-bit operands (0 to 30), and neg_o is 0.
- R2: With op_i = 2'b01, result_o equals the magnitude |a_i - b_i| of the 4-bit operands.
- R3: neg_o is 1 only when op_i = 2'b01 and b_i > a_i. A zero result, and every other operation, leaves it 0.
- R4: With op_i = 2'b10, result_o equals a_i[2:0] * b_i[2:0] (up to 49), including columns where several partial products and carries meet.
- R5: With op_i = 2'b11 and b_i[1:0] != 0, result_o equals floor(a_i[1:0] / b_i[1:0]) and rem_o equals a_i[1:0] mod b_i[1:0].
- R6: With op_i = 2'b11 and b_i[1:0] = 0, div_err_o is 1, result_o and rem_o are 0, and both segment outputs are all zeros (blank).
- R7: Operand bits above the selected operation's width do not affect any output. div_err_o and rem_o are 0 for every operation other than divide.
- R8: units_seg_o shows result_o mod 10 and tens_seg_o shows result_o / 10. Both are active-high with bit 6 = segment a down to bit 0 = segment g, using glyphs 0=7E, 1=30, 2=6D, 3=79, 4=33, 5=5B, 6=5F, 7=70, 8=7F, 9=7B (hex).
- R9: tens_seg_o is blank (all zeros) whenever the tens digit is 0, while units_seg_o still shows the glyph for 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First operand (minuend, multiplicand, dividend) |
| b_i | input | 4 | Second operand (subtrahend, multiplier, divisor) |
| op_i | input | 2 | Operation: 00 add, 01 subtract, 10 multiply, 11 divide |
| result_o | output | 6 | Binary result (sum, magnitude, product or quotient) |
| neg_o | output | 1 | Subtraction result is negative |
| div_err_o | output | 1 | Divide by zero |
| rem_o | output | 2 | Division remainder |
| tens_seg_o | output | 7 | Tens digit segments a..g, active-high |
| units_seg_o | output | 7 | Units digit segments a..g, active-high |

## Verification
A table of hand-picked vectors targets the edges of each operation. It includes the largest sum 15+15, which proves the carry out reaches bit 4. It includes 7x7, where the middle multiplier column produces a double carry, and equal subtraction operands, which must give a zero with the sign clear. It also covers subtrahends above the minuend, with 0-15 as the extreme magnitude, division by zero, and operands with high bits set under multiply and divide, which separate correct masking from full-width use. An exhaustive sweep of all 1024 operation and operand combinations then compares every output, segments included, against an arithmetic model. This catches any single wrong chain bit, glyph or blanking rule.

// File: rtl/calc_pkg.sv
package calc_pkg;
  localparam int unsigned OPND_W = 4;   // add/sub operand width
  localparam int unsigned MUL_W  = 3;   // multiply operand width
  localparam int unsigned DIV_W  = 2;   // divide operand width
  localparam int unsigned RES_W  = 2 * MUL_W;
  localparam int unsigned DIG_N  = 2;
  localparam int unsigned BCD_W  = 4;
  localparam int unsigned SEG_W  = 7;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_DIV = 2'b11
  } calc_op_e;

  // {carry, sum}
  function automatic logic [1:0] fa(input logic x, input logic y, input logic ci);
    return {(x & y) | (ci & (x ^ y)), x ^ y ^ ci};
  endfunction
endpackage

// File: rtl/calc_ripple_addsub.sv
module calc_ripple_addsub #(
  parameter int unsigned W = calc_pkg::OPND_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W:0]   res_o,
  output logic         neg_o
);
  logic [W:0]   cy, bw;
  logic [W-1:0] s, d, mag;

  assign cy[0] = 1'b0;
  assign bw[0] = 1'b0;

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign {cy[g+1], s[g]} = calc_pkg::fa(a_i[g], b_i[g], cy[g]);
    assign d[g]    = a_i[g] ^ b_i[g] ^ bw[g];
    assign bw[g+1] = (~a_i[g] & b_i[g]) | (~(a_i[g] ^ b_i[g]) & bw[g]);
  end

  // second complement turns a negative raw difference into its magnitude
  assign mag   = bw[W] ? (~d + 1'b1) : d;
  assign res_o = sub_i ? {1'b0, mag} : {cy[W], s};
  assign neg_o = sub_i & bw[W];

  always_comb begin
    if (!$isunknown({a_i, b_i, sub_i})) begin
      if (!sub_i) begin
        assert_sum_R1: assert (res_o == (W+1)'(a_i) + (W+1)'(b_i))
          else $error("R1 sum mismatch");
      end else begin
        assert_sign_R3: assert (neg_o == (b_i > a_i))
          else $error("R3 sign mismatch");
        assert_mag_R2: assert (neg_o ? ((W+1)'(a_i) + res_o == (W+1)'(b_i))
                                     : ((W+1)'(b_i) + res_o == (W+1)'(a_i)))
          else $error("R2 magnitude mismatch");
      end
    end
  end
endmodule

// File: rtl/calc_array_mult.sv
module calc_array_mult #(
  parameter int unsigned W = calc_pkg::MUL_W
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  localparam int unsigned PW = 2 * W;

  logic [W-1:0][PW-1:0] acc;

  assign acc[0] = {{W{1'b0}}, a_i & {W{b_i[0]}}};

  // each row ripples a shifted partial product into the running sum
  for (genvar i = 1; i < W; i++) begin : g_row
    logic [PW-1:0] pp;
    logic [PW-1:0] cc;
    assign pp    = PW'({{W{1'b0}}, a_i & {W{b_i[i]}}} << i);
    assign cc[0] = 1'b0;
    for (genvar j = 0; j < PW; j++) begin : g_col
      if (j < PW - 1) begin : g_fa
        assign {cc[j+1], acc[i][j]} = calc_pkg::fa(acc[i-1][j], pp[j], cc[j]);
      end else begin : g_top
        assign acc[i][j] = acc[i-1][j] ^ pp[j] ^ cc[j];
      end
    end
  end

  assign p_o = acc[W-1];

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      assert_product_R4: assert (p_o == PW'(a_i) * PW'(b_i))
        else $error("R4 product mismatch");
    end
  end
endmodule

// File: rtl/calc_divider.sv
module calc_divider #(
  parameter int unsigned W = calc_pkg::DIV_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] r_o,
  output logic         err_o
);
  logic [W:0]   part;
  logic [W-1:0] q_raw;

  always_comb begin
    part  = '0;
    q_raw = '0;
    for (int i = W - 1; i >= 0; i--) begin
      part = {part[W-1:0], a_i[i]};
      if (part >= {1'b0, b_i}) begin
        part     = part - {1'b0, b_i};
        q_raw[i] = 1'b1;
      end
    end
  end

  assign err_o = (b_i == '0);
  assign q_o   = err_o ? '0 : q_raw;
  assign r_o   = err_o ? '0 : part[W-1:0];

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      if (!err_o) begin
        assert_quot_R5: assert ((2*W)'(q_o) * (2*W)'(b_i) + (2*W)'(r_o) == (2*W)'(a_i) && r_o < b_i)
          else $error("R5 quotient mismatch");
      end else begin
        assert_zero_div_R6: assert (q_o == '0 && r_o == '0)
          else $error("R6 divide by zero not cleared");
      end
    end
  end
endmodule

// File: rtl/calc_bin2bcd.sv
module calc_bin2bcd #(
  parameter int unsigned BIN_W = calc_pkg::RES_W,
  parameter int unsigned DIG   = calc_pkg::DIG_N
) (
  input  logic [BIN_W-1:0]   bin_i,
  output logic [DIG*4-1:0]   bcd_o
);
  localparam int unsigned SW = DIG * 4 + BIN_W;

  logic [SW-1:0] sh;

  // shift-and-add-3
  always_comb begin
    sh = SW'(bin_i);
    for (int i = 0; i < BIN_W; i++) begin
      for (int k = 0; k < DIG; k++) begin
        if (sh[BIN_W + 4*k +: 4] >= 4'd5) sh[BIN_W + 4*k +: 4] = sh[BIN_W + 4*k +: 4] + 4'd3;
      end
      sh = sh << 1;
    end
  end

  assign bcd_o = sh[BIN_W +: DIG*4];

  always_comb begin
    if (!$isunknown(bin_i)) begin
      assert_bcd_R8: assert (32'(bcd_o[7:4]) * 10 + 32'(bcd_o[3:0]) == 32'(bin_i) && bcd_o[3:0] <= 4'd9)
        else $error("R8 bcd mismatch");
    end
  end
endmodule

// File: rtl/calc_seg7.sv
module calc_seg7 (
  input  logic [calc_pkg::BCD_W-1:0] dig_i,
  input  logic                       blank_i,
  output logic [calc_pkg::SEG_W-1:0] seg_o
);
  logic [calc_pkg::SEG_W-1:0] glyph;

  // bit 6 = a ... bit 0 = g
  always_comb begin
    unique case (dig_i)
      4'd0:    glyph = 7'h7E;
      4'd1:    glyph = 7'h30;
      4'd2:    glyph = 7'h6D;
      4'd3:    glyph = 7'h79;
      4'd4:    glyph = 7'h33;
      4'd5:    glyph = 7'h5B;
      4'd6:    glyph = 7'h5F;
      4'd7:    glyph = 7'h70;
      4'd8:    glyph = 7'h7F;
      4'd9:    glyph = 7'h7B;
      default: glyph = 7'h00;
    endcase
  end

  assign seg_o = blank_i ? '0 : glyph;

  always_comb begin
    if (!$isunknown({dig_i, blank_i})) begin
      assert_lit_R8: assert (blank_i || dig_i > 4'd9 || seg_o != '0)
        else $error("R8 digit not lit");
    end
  end
endmodule

// File: rtl/calc_core.sv
module calc_core
  import calc_pkg::*;
(
  input  logic [OPND_W-1:0] a_i,
  input  logic [OPND_W-1:0] b_i,
  input  logic [1:0]        op_i,
  output logic [RES_W-1:0]  result_o,
  output logic              neg_o,
  output logic              div_err_o,
  output logic [DIV_W-1:0]  rem_o,
  output logic [SEG_W-1:0]  tens_seg_o,
  output logic [SEG_W-1:0]  units_seg_o
);
  calc_op_e op;
  assign op = calc_op_e'(op_i);

  logic [OPND_W:0]      as_res;
  logic                 as_neg;
  logic [2*MUL_W-1:0]   prod;
  logic [DIV_W-1:0]     quot, rem;
  logic                 dz;
  logic [DIG_N*4-1:0]   bcd;
  logic                 blank_all;

  calc_ripple_addsub #(.W(OPND_W)) u_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (op == OP_SUB),
    .res_o (as_res),
    .neg_o (as_neg)
  );

  // operand masking: each unit sees only its own low bits
  calc_array_mult #(.W(MUL_W)) u_mult (
    .a_i (a_i[MUL_W-1:0]),
    .b_i (b_i[MUL_W-1:0]),
    .p_o (prod)
  );

  calc_divider #(.W(DIV_W)) u_div (
    .a_i   (a_i[DIV_W-1:0]),
    .b_i   (b_i[DIV_W-1:0]),
    .q_o   (quot),
    .r_o   (rem),
    .err_o (dz)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: result_o = RES_W'(as_res);
      OP_MUL:         result_o = RES_W'(prod);
      default:        result_o = RES_W'(quot);
    endcase
  end

  assign neg_o     = (op == OP_SUB) & as_neg;
  assign div_err_o = (op == OP_DIV) & dz;
  assign rem_o     = (op == OP_DIV) ? rem : '0;
  assign blank_all = div_err_o;

  calc_bin2bcd #(.BIN_W(RES_W), .DIG(DIG_N)) u_bcd (
    .bin_i (result_o),
    .bcd_o (bcd)
  );

  calc_seg7 u_seg_tens (
    .dig_i   (bcd[7:4]),
    .blank_i (blank_all | (bcd[7:4] == 4'd0)),
    .seg_o   (tens_seg_o)
  );

  calc_seg7 u_seg_units (
    .dig_i   (bcd[3:0]),
    .blank_i (blank_all),
    .seg_o   (units_seg_o)
  );

  always_comb begin
    if (!$isunknown({a_i, b_i, op_i})) begin
      assert_neg_only_sub_R3: assert (!neg_o || (op_i == 2'b01 && result_o != '0))
        else $error("R3 neg flag misuse");
      assert_dz_blank_R6: assert (!div_err_o || (tens_seg_o == '0 && units_seg_o == '0 && result_o == '0))
        else $error("R6 display not blanked");
      assert_div_only_R7: assert (op_i == 2'b11 || (!div_err_o && rem_o == '0))
        else $error("R7 divide outputs leak");
      assert_tens_blank_R9: assert (result_o >= RES_W'(10) || tens_seg_o == '0)
        else $error("R9 tens not blanked");
    end
  end
endmodule

// File: tb/calc_core_test.sv
module calc_core_test;
  logic       clk = 1'b0;
  logic [3:0] a, b;
  logic [1:0] op;
  logic [5:0] result;
  logic       neg, derr;
  logic [1:0] rem;
  logic [6:0] tseg, useg;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  calc_core uut (
    .a_i(a), .b_i(b), .op_i(op),
    .result_o(result), .neg_o(neg), .div_err_o(derr), .rem_o(rem),
    .tens_seg_o(tseg), .units_seg_o(useg)
  );

  function automatic logic [6:0] glyph(input int d);
    case (d)
      0: return 7'h7E; 1: return 7'h30; 2: return 7'h6D; 3: return 7'h79;
      4: return 7'h33; 5: return 7'h5B; 6: return 7'h5F; 7: return 7'h70;
      8: return 7'h7F; 9: return 7'h7B; default: return 7'h00;
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s op=%0d a=%0d b=%0d actual=%0h expected=%0h", req, what, op, a, b, act, exp);
    end
  endtask

  // {op, a, b, result, neg, err, rem}
  localparam int NV = 17;
  localparam logic [19:0] VEC [NV] = '{
    {2'd0, 4'd0,  4'd0,  6'd0,  1'b0, 1'b0, 2'd0},  // R1 zero
    {2'd0, 4'd15, 4'd15, 6'd30, 1'b0, 1'b0, 2'd0},  // R1 max carry
    {2'd0, 4'd9,  4'd7,  6'd16, 1'b0, 1'b0, 2'd0},  // R1
    {2'd1, 4'd9,  4'd4,  6'd5,  1'b0, 1'b0, 2'd0},  // R2
    {2'd1, 4'd4,  4'd9,  6'd5,  1'b1, 1'b0, 2'd0},  // R2 R3 negative
    {2'd1, 4'd0,  4'd15, 6'd15, 1'b1, 1'b0, 2'd0},  // R2 R3 extreme
    {2'd1, 4'd7,  4'd7,  6'd0,  1'b0, 1'b0, 2'd0},  // R3 zero clears
    {2'd2, 4'd7,  4'd7,  6'd49, 1'b0, 1'b0, 2'd0},  // R4 double carry
    {2'd2, 4'd5,  4'd6,  6'd30, 1'b0, 1'b0, 2'd0},  // R4
    {2'd2, 4'd3,  4'd7,  6'd21, 1'b0, 1'b0, 2'd0},  // R4
    {2'd2, 4'd15, 4'd9,  6'd7,  1'b0, 1'b0, 2'd0},  // R7 mask mul
    {2'd3, 4'd3,  4'd2,  6'd1,  1'b0, 1'b0, 2'd1},  // R5
    {2'd3, 4'd3,  4'd1,  6'd3,  1'b0, 1'b0, 2'd0},  // R5
    {2'd3, 4'd1,  4'd3,  6'd0,  1'b0, 1'b0, 2'd1},  // R5
    {2'd3, 4'd2,  4'd0,  6'd0,  1'b0, 1'b1, 2'd0},  // R6
    {2'd3, 4'd14, 4'd4,  6'd0,  1'b0, 1'b1, 2'd0},  // R6 R7 masked zero
    {2'd3, 4'd14, 4'd7,  6'd0,  1'b0, 1'b0, 2'd2}   // R7 mask div
  };

  task automatic apply(input logic [1:0] o, input logic [3:0] x, input logic [3:0] y);
    @(posedge clk);
    op = o; a = x; b = y;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    op = 2'd0; a = 4'd0; b = 4'd0;
    @(negedge clk);
    // idle state: 0+0
    check("R9", "tens blank idle", 32'(tseg), 32'h00);
    check("R8", "units zero idle", 32'(useg), 32'h7E);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][19:18], VEC[i][17:14], VEC[i][13:10]);
      check("R1/R2/R4/R5", "result", 32'(result), 32'(VEC[i][9:4]));
      check("R3", "neg", 32'(neg), 32'(VEC[i][3]));
      check("R6", "div_err", 32'(derr), 32'(VEC[i][2]));
      check("R5/R7", "rem", 32'(rem), 32'(VEC[i][1:0]));
    end

    // directed corner checks on segments
    apply(2'd2, 4'd7, 4'd7);
    check("R8", "tens 49", 32'(tseg), 32'h33);
    check("R8", "units 49", 32'(useg), 32'h7B);
    apply(2'd0, 4'd4, 4'd5);
    check("R9", "tens blank 9", 32'(tseg), 32'h00);
    check("R8", "units 9", 32'(useg), 32'h7B);
    apply(2'd3, 4'd3, 4'd0);
    check("R6", "tens blank dz", 32'(tseg), 32'h00);
    check("R6", "units blank dz", 32'(useg), 32'h00);
    apply(2'd0, 4'd7, 4'd3);
    check("R9", "units 0 with tens 1", 32'(useg), 32'h7E);
    check("R8", "tens 1", 32'(tseg), 32'h30);

    // exhaustive sweep against arithmetic model
    for (int o = 0; o < 4; o++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          int r, rm; bit ng, er;
          logic [6:0] et, eu;
          r = 0; rm = 0; ng = 0; er = 0;
          case (o)
            0: r = x + y;
            1: begin if (y > x) begin r = y - x; ng = 1; end else r = x - y; end
            2: r = (x % 8) * (y % 8);
            default: begin
              if ((y % 4) == 0) er = 1;
              else begin r = (x % 4) / (y % 4); rm = (x % 4) % (y % 4); end
            end
          endcase
          eu = er ? 7'h00 : glyph(r % 10);
          et = (er || (r / 10) == 0) ? 7'h00 : glyph(r / 10);
          apply(2'(o), 4'(x), 4'(y));
          check("R1-sweep R2 R3 R4 R5 R6 R7 R8 R9", "all outputs",
                {result, neg, derr, rem, tseg, useg},
                {6'(r), ng, er, 2'(rm), et, eu});
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule